// File: doc/BRIEF.md
# SECDED Read-Path Decoder with First-Error Capture

This block sits on the read path of a non-volatile memory. Every stored word is 72 bits wide: 64 data bits protected by 8 check bits. Words arrive with a read-valid strobe, together with the access address and the ID of the bus master that asked for them. The block hands the data on one clock later. Any single flipped bit is repaired on the way. Any two flipped bits are flagged as uncorrectable, and the data is then passed on as it was read.

The first error seen is recorded for software in a small status record. The record holds a correction flag, a detection flag, the failing word's address aligned to 64-bit words, and the master ID. The record then stays frozen until software clears the flags. A corrected error raises an interrupt only if software has enabled it. An uncorrectable error always raises a non-maskable request. A one-cycle configuration write port clears flags and sets the interrupt enable. A purely combinational encoder port produces check bits for test patterns and for the write path.

Top module: `mem_secded_guard`

## Requirements
- R1: Word layout. Bits [63:0] hold the data. Bit 64+k (k = 0..6) is the XOR of every data bit whose Hamming position has bit k set. Data bits occupy the positions 3..71 that are not powers of two, in ascending order, data bit 0 first. Bit 71 makes the XOR of all 72 bits zero. `enc_word` gives this word for `enc_data` combinationally.
- R2: For an error-free word, `out_valid` pulses high for exactly one cycle, one clock after `rd_valid`. In that cycle `out_data` equals the data bits, and `out_corrected` and `out_uncorrectable` are 0. No flag changes.
- R3: If exactly one of the 72 bits is flipped (data, check or overall-parity bit), `out_data` is the original data and `out_corrected` is 1 for that output.
- R4: If exactly two bits are flipped, `out_uncorrectable` is 1, `out_corrected` is 0, and `out_data` equals bits [63:0] of the word as received.
- R5: When an error arrives while both flags are clear, the matching flag sets in the same cycle as the output. `capt_addr` then takes `rd_addr[16:0]` with bits [2:0] forced to 0, and `capt_master` takes `rd_master`.
- R6: `irq_corr` is high exactly while the correction flag is set and the interrupt enable is 1. The enable is loaded from `cfg_wdata[2]` on every configuration write and is 0 after reset.
- R7: An uncorrectable error sets `flag_det`. `nmi_req` follows `flag_det` whatever the interrupt enable is.
- R8: While either flag is set, further errors change neither flag, `capt_addr` nor `capt_master`.
- R9: A configuration write with `cfg_wdata[0]`=1 clears the correction flag, and one with `cfg_wdata[1]`=1 clears the detection flag. Zero bits leave the flags alone. Once the flags are cleared, the next error is captured again, including an error that arrives in the same cycle as the clearing write.
- R10: After reset, `out_valid`, both flags, `capt_addr`, `capt_master`, `irq_corr` and `nmi_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_valid | input | 1 | Read word strobe |
| rd_word | input | 72 | Word read from memory |
| rd_addr | input | 20 | Byte address of the access |
| rd_master | input | 3 | ID of the requesting bus master |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 3 | Bit0 clear correction flag, bit1 clear detection flag, bit2 interrupt enable |
| enc_data | input | 64 | Data to encode |
| enc_word | output | 72 | Encoded word for enc_data |
| out_valid | output | 1 | Output data valid |
| out_data | output | 64 | Corrected data |
| out_corrected | output | 1 | This output had a single-bit error repaired |
| out_uncorrectable | output | 1 | This output had a double-bit error |
| flag_corr | output | 1 | Captured correction flag |
| flag_det | output | 1 | Captured detection flag |
| capt_addr | output | 17 | Captured word-aligned address |
| capt_master | output | 3 | Captured master ID |
| irq_corr | output | 1 | Maskable correction interrupt |
| nmi_req | output | 1 | Non-maskable uncorrectable-error request |

## Verification
Decoded data, the per-read error bits, both flags, the capture record and both interrupt lines are all due exactly one clock after the read strobe or configuration write that caused them. The encoder output is due in the same cycle. The bench drives its inputs on a falling edge. Data and error bits are compared from a scoreboard queue at the next falling edge, where `out_valid` must be high. The capture record and the interrupt lines are checked at that same falling edge, once the driving task returns. Encoder results are compared one time step after `enc_data` changes.

// File: rtl/secded_pkg.sv
package secded_pkg;

   // configuration write field positions
   localparam int CFG_W        = 3;
   localparam int CLR_CORR_BIT = 0;
   localparam int CLR_DET_BIT  = 1;
   localparam int IEN_BIT      = 2;

   // number of Hamming check bits needed for dw data bits
   function automatic int ham_bits(input int dw);
      for (int r = 1; r < 31; r++) begin
         if ((1 << r) >= dw + r + 1) return r;
      end
      return 31;
   endfunction

   // Hamming position of data bit idx (non-powers of two from 3 up)
   function automatic int data_pos(input int idx);
      int cnt;
      cnt = 0;
      for (int p = 3; p < 4096; p++) begin
         if ((p & (p - 1)) != 0) begin
            if (cnt == idx) return p;
            cnt++;
         end
      end
      return 0;
   endfunction

endpackage

// File: rtl/secded_enc.sv
module secded_enc #(
   parameter int DATA_W = 64,
   localparam int HAM_W  = secded_pkg::ham_bits(DATA_W),
   localparam int WORD_W = DATA_W + HAM_W + 1
) (
   input  logic [DATA_W-1:0] data_i,
   output logic [WORD_W-1:0] word_o
);

   function automatic logic [DATA_W-1:0] col_mask(input int k);
      logic [DATA_W-1:0] m;
      m = '0;
      for (int i = 0; i < DATA_W; i++) begin
         if (((secded_pkg::data_pos(i) >> k) & 1) == 1) m[i] = 1'b1;
      end
      return m;
   endfunction

   logic [HAM_W-1:0] ham;

   for (genvar k = 0; k < HAM_W; k++) begin : g_chk
      localparam logic [DATA_W-1:0] MASK = col_mask(k);
      assign ham[k] = ^(data_i & MASK);
   end

   assign word_o = {^{ham, data_i}, ham, data_i};

endmodule

// File: rtl/secded_dec.sv
module secded_dec #(
   parameter int DATA_W = 64,
   localparam int HAM_W  = secded_pkg::ham_bits(DATA_W),
   localparam int WORD_W = DATA_W + HAM_W + 1
) (
   input  logic [WORD_W-1:0] word_i,
   output logic [DATA_W-1:0] data_o,
   output logic              corr_o,
   output logic              det_o
);

   localparam int MAX_POS = DATA_W + HAM_W;
   localparam logic [HAM_W-1:0] MAX_SYN = HAM_W'(MAX_POS);

   logic [WORD_W-1:0] recalc;
   logic [HAM_W-1:0]  syn;
   logic [DATA_W-1:0] flip;
   logic              odd, nz, in_range;
   logic              unused_recalc_par;

   secded_enc #(.DATA_W(DATA_W)) u_recalc (
      .data_i (word_i[DATA_W-1:0]),
      .word_o (recalc)
   );

   assign unused_recalc_par = recalc[WORD_W-1];
   assign syn      = word_i[DATA_W +: HAM_W] ^ recalc[DATA_W +: HAM_W];
   assign odd      = ^word_i;
   assign nz       = |syn;
   assign in_range = (syn <= MAX_SYN);

   // odd parity: one flip (syndrome 0 means the parity bit itself)
   // even parity with nonzero syndrome, or an impossible position: two flips
   assign corr_o = odd && (!nz || in_range);
   assign det_o  = (!odd && nz) || (odd && !in_range);

   for (genvar i = 0; i < DATA_W; i++) begin : g_fix
      localparam logic [HAM_W-1:0] P_SYN = HAM_W'(secded_pkg::data_pos(i));
      assign flip[i] = odd && (syn == P_SYN);
   end

   assign data_o = word_i[DATA_W-1:0] ^ flip;

endmodule

// File: rtl/ecc_capture.sv
module ecc_capture #(
   parameter int ADDR_W     = 20,
   parameter int CAPT_W     = 17,
   parameter int ALIGN_BITS = 3,
   parameter int ID_W       = 3
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         evt_i,
   input  logic                         corr_i,
   input  logic                         det_i,
   input  logic [ADDR_W-1:0]            addr_i,
   input  logic [ID_W-1:0]              id_i,
   input  logic                         wr_en_i,
   input  logic [secded_pkg::CFG_W-1:0] wr_data_i,
   output logic                         flag_corr_o,
   output logic                         flag_det_o,
   output logic                         irq_en_o,
   output logic [CAPT_W-1:0]            capt_addr_o,
   output logic [ID_W-1:0]              capt_id_o
);
   import secded_pkg::*;

   logic [CAPT_W-1:0] aligned;
   logic              corr_q, det_q, ien_q;
   logic              corr_keep, det_keep, take;
   logic [CAPT_W-1:0] addr_q;
   logic [ID_W-1:0]   id_q;

   if (ALIGN_BITS == 0) begin : g_noalign
      assign aligned = addr_i[CAPT_W-1:0];
      if (ADDR_W > CAPT_W) begin : g_hi
         logic unused_addr_hi;
         assign unused_addr_hi = ^addr_i[ADDR_W-1:CAPT_W];
      end
   end else begin : g_align
      logic unused_addr_bits;
      assign aligned = {addr_i[CAPT_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
      if (ADDR_W > CAPT_W) begin : g_hi
         assign unused_addr_bits = ^{addr_i[ADDR_W-1:CAPT_W], addr_i[ALIGN_BITS-1:0]};
      end else begin : g_lo
         assign unused_addr_bits = ^addr_i[ALIGN_BITS-1:0];
      end
   end

   // flag values after this cycle's clearing write
   assign corr_keep = corr_q & ~(wr_en_i & wr_data_i[CLR_CORR_BIT]);
   assign det_keep  = det_q  & ~(wr_en_i & wr_data_i[CLR_DET_BIT]);
   assign take      = evt_i && (corr_i || det_i) && !corr_keep && !det_keep;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         corr_q <= 1'b0;
         det_q  <= 1'b0;
         ien_q  <= 1'b0;
         addr_q <= '0;
         id_q   <= '0;
      end else begin
         if (wr_en_i) ien_q <= wr_data_i[IEN_BIT];
         if (take) begin
            det_q  <= det_i;
            corr_q <= corr_i && !det_i;
            addr_q <= aligned;
            id_q   <= id_i;
         end else begin
            corr_q <= corr_keep;
            det_q  <= det_keep;
         end
      end
   end

   assign flag_corr_o = corr_q;
   assign flag_det_o  = det_q;
   assign irq_en_o    = ien_q;
   assign capt_addr_o = addr_q;
   assign capt_id_o   = id_q;

endmodule

// File: rtl/mem_secded_guard.sv
module mem_secded_guard #(
   parameter int DATA_W     = 64,
   parameter int ADDR_W     = 20,
   parameter int CAPT_W     = 17,
   parameter int ALIGN_BITS = 3,
   parameter int ID_W       = 3,
   localparam int HAM_W     = secded_pkg::ham_bits(DATA_W),
   localparam int WORD_W    = DATA_W + HAM_W + 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         rd_valid,
   input  logic [WORD_W-1:0]            rd_word,
   input  logic [ADDR_W-1:0]            rd_addr,
   input  logic [ID_W-1:0]              rd_master,
   input  logic                         cfg_wr,
   input  logic [secded_pkg::CFG_W-1:0] cfg_wdata,
   input  logic [DATA_W-1:0]            enc_data,
   output logic [WORD_W-1:0]            enc_word,
   output logic                         out_valid,
   output logic [DATA_W-1:0]            out_data,
   output logic                         out_corrected,
   output logic                         out_uncorrectable,
   output logic                         flag_corr,
   output logic                         flag_det,
   output logic [CAPT_W-1:0]            capt_addr,
   output logic [ID_W-1:0]              capt_master,
   output logic                         irq_corr,
   output logic                         nmi_req
);

   initial begin : prm_chk
      assert (DATA_W >= 4 && DATA_W <= 1024) else $error("DATA_W out of range");
      assert (CAPT_W <= ADDR_W) else $error("CAPT_W wider than ADDR_W");
      assert (ALIGN_BITS >= 0 && ALIGN_BITS < CAPT_W) else $error("ALIGN_BITS out of range");
      assert (ID_W >= 1) else $error("ID_W must be positive");
   end

   logic [DATA_W-1:0] dec_data;
   logic              dec_corr, dec_det, irq_en;

   secded_enc #(.DATA_W(DATA_W)) u_enc (
      .data_i (enc_data),
      .word_o (enc_word)
   );

   secded_dec #(.DATA_W(DATA_W)) u_dec (
      .word_i (rd_word),
      .data_o (dec_data),
      .corr_o (dec_corr),
      .det_o  (dec_det)
   );

   ecc_capture #(
      .ADDR_W(ADDR_W), .CAPT_W(CAPT_W), .ALIGN_BITS(ALIGN_BITS), .ID_W(ID_W)
   ) u_capt (
      .clk         (clk),
      .rst_n       (rst_n),
      .evt_i       (rd_valid),
      .corr_i      (dec_corr),
      .det_i       (dec_det),
      .addr_i      (rd_addr),
      .id_i        (rd_master),
      .wr_en_i     (cfg_wr),
      .wr_data_i   (cfg_wdata),
      .flag_corr_o (flag_corr),
      .flag_det_o  (flag_det),
      .irq_en_o    (irq_en),
      .capt_addr_o (capt_addr),
      .capt_id_o   (capt_master)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid         <= 1'b0;
         out_data          <= '0;
         out_corrected     <= 1'b0;
         out_uncorrectable <= 1'b0;
      end else begin
         out_valid         <= rd_valid;
         out_corrected     <= rd_valid & dec_corr;
         out_uncorrectable <= rd_valid & dec_det;
         if (rd_valid) out_data <= dec_data;
      end
   end

   assign irq_corr = flag_corr & irq_en;
   assign nmi_req  = flag_det;

endmodule

// File: rtl/secded_guard_chk.sv
module secded_guard_chk #(
   parameter int CAPT_W = 17,
   parameter int ID_W   = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_valid,
   input logic              cfg_wr,
   input logic              out_valid,
   input logic              out_corrected,
   input logic              out_uncorrectable,
   input logic              flag_corr,
   input logic              flag_det,
   input logic [CAPT_W-1:0] capt_addr,
   input logic [ID_W-1:0]   capt_master,
   input logic              irq_corr,
   input logic              nmi_req
);

   // R2
   valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> out_valid);

   // R2
   valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid |=> !out_valid);

   // R4
   err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_corrected && out_uncorrectable));

   // R3
   corr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_corr) |-> out_corrected);

   // R7
   nmi_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nmi_req) |-> out_uncorrectable);

   // R6
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_corr |-> flag_corr);

   // R8
   flag_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({flag_corr, flag_det}));

   // R8
   capt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_corr || flag_det) && !cfg_wr |=> $stable(capt_addr) && $stable(capt_master));

endmodule

bind mem_secded_guard secded_guard_chk #(.CAPT_W(CAPT_W), .ID_W(ID_W)) u_chk (
   .clk               (clk),
   .rst_n             (rst_n),
   .rd_valid          (rd_valid),
   .cfg_wr            (cfg_wr),
   .out_valid         (out_valid),
   .out_corrected     (out_corrected),
   .out_uncorrectable (out_uncorrectable),
   .flag_corr         (flag_corr),
   .flag_det          (flag_det),
   .capt_addr         (capt_addr),
   .capt_master       (capt_master),
   .irq_corr          (irq_corr),
   .nmi_req           (nmi_req)
);

// File: tb/mem_secded_guard_bench.sv
`timescale 1ns/1ps
module mem_secded_guard_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rd_valid = 1'b0;
   logic [71:0] rd_word = '0;
   logic [19:0] rd_addr = '0;
   logic [2:0]  rd_master = '0;
   logic        cfg_wr = 1'b0;
   logic [2:0]  cfg_wdata = '0;
   logic [63:0] enc_data = '0;
   logic [71:0] enc_word;
   logic        out_valid, out_corrected, out_uncorrectable;
   logic [63:0] out_data;
   logic        flag_corr, flag_det, irq_corr, nmi_req;
   logic [16:0] capt_addr;
   logic [2:0]  capt_master;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   typedef struct packed {
      logic [63:0] d;
      logic        c;
      logic        u;
   } exp_t;
   exp_t sbq[$];

   always #2 clk = ~clk;

   mem_secded_guard u_mem_secded_guard (
      .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_word(rd_word),
      .rd_addr(rd_addr), .rd_master(rd_master), .cfg_wr(cfg_wr),
      .cfg_wdata(cfg_wdata), .enc_data(enc_data), .enc_word(enc_word),
      .out_valid(out_valid), .out_data(out_data), .out_corrected(out_corrected),
      .out_uncorrectable(out_uncorrectable), .flag_corr(flag_corr),
      .flag_det(flag_det), .capt_addr(capt_addr), .capt_master(capt_master),
      .irq_corr(irq_corr), .nmi_req(nmi_req)
   );

   task automatic check(input bit ok, input string tag,
                        input logic [127:0] act, input logic [127:0] expv);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
      end
   endtask

   // independent encoder built from the R1 layout
   function automatic logic [71:0] benc(input logic [63:0] d);
      logic [127:0] pb;
      logic [71:0]  w;
      int           di;
      pb = '0;
      di = 0;
      for (int p = 1; p <= 71; p++) begin
         if ((p & (p - 1)) != 0) begin
            pb[p] = d[di];
            di++;
         end
      end
      w = '0;
      w[63:0] = d;
      for (int k = 0; k < 7; k++) begin
         logic c;
         c = 1'b0;
         for (int p = 1; p <= 71; p++) if (((p >> k) & 1) == 1) c ^= pb[p];
         w[64+k] = c;
      end
      w[71] = ^w[70:0];
      return w;
   endfunction

   function automatic logic [16:0] align(input logic [19:0] a);
      return {a[16:3], 3'b000};
   endfunction

   // driver: push expectation, present one word for one cycle
   task automatic rd(input logic [71:0] w, input logic [19:0] a, input logic [2:0] id,
                     input logic [63:0] ed, input logic ec, input logic eu);
      exp_t e;
      e.d = ed; e.c = ec; e.u = eu;
      sbq.push_back(e);
      @(negedge clk);
      rd_valid = 1'b1; rd_word = w; rd_addr = a; rd_master = id;
      @(negedge clk);
      rd_valid = 1'b0;
   endtask

   task automatic wr(input logic [2:0] v);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_wdata = v;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   // monitor: compare each output against the scoreboard head
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (sbq.size() == 0) begin
            check(1'b0, "R2 unexpected out_valid", 1, 0);
         end else begin
            exp_t e;
            e = sbq.pop_front();
            check(out_data == e.d, "R2/R3/R4 out_data", out_data, e.d);
            check(out_corrected == e.c, "R3 out_corrected", out_corrected, e.c);
            check(out_uncorrectable == e.u, "R4 out_uncorrectable", out_uncorrectable, e.u);
         end
      end
   end

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin : main
      logic [63:0] pats [5];
      logic [63:0] p;
      logic [71:0] w;
      pats[0] = 64'h0;
      pats[1] = 64'hFFFF_FFFF_FFFF_FFFF;
      pats[2] = 64'hA5A5_5A5A_0F0F_F0F0;
      pats[3] = 64'h0123_4567_89AB_CDEF;
      pats[4] = 64'h8000_0000_0000_0001;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      check(out_valid == 0, "R10 out_valid", out_valid, 0);
      check({flag_corr, flag_det} == 0, "R10 flags", {flag_corr, flag_det}, 0);
      check(capt_addr == 0 && capt_master == 0, "R10 capture", {capt_addr, capt_master}, 0);
      check({irq_corr, nmi_req} == 0, "R10 irq/nmi", {irq_corr, nmi_req}, 0);

      // R1 encoder port
      for (int i = 0; i < 5; i++) begin
         enc_data = pats[i];
         #1;
         check(enc_word == benc(pats[i]), "R1 enc_word", enc_word, benc(pats[i]));
      end

      // R2 clean reads
      for (int i = 0; i < 5; i++) rd(benc(pats[i]), 20'h00100 + 20'(i * 8), 3'(i), pats[i], 0, 0);
      check({flag_corr, flag_det} == 0, "R2 no flag on clean reads", {flag_corr, flag_det}, 0);

      // R5 first single-bit error captured, R6 masked
      wr(3'b000);
      p = pats[3];
      rd(benc(p) ^ (72'd1 << 10), 20'hABCDF, 3'd5, p, 1, 0);
      check(flag_corr == 1 && flag_det == 0, "R5 flag_corr set", {flag_corr, flag_det}, 2'b10);
      check(capt_addr == align(20'hABCDF), "R5 capt_addr", capt_addr, align(20'hABCDF));
      check(capt_master == 3'd5, "R5 capt_master", capt_master, 5);
      check(irq_corr == 0, "R6 irq masked", irq_corr, 0);
      check(nmi_req == 0, "R7 no nmi on single", nmi_req, 0);

      // R6 enable; R9 zero clear bits have no effect
      wr(3'b100);
      check(irq_corr == 1, "R6 irq enabled", irq_corr, 1);
      check(flag_corr == 1, "R9 zero bits keep flag", flag_corr, 1);

      // R3 every single position, R8 locked
      for (int i = 0; i < 72; i++) begin
         p = pats[i % 5] ^ 64'(i);
         rd(benc(p) ^ (72'd1 << i), 20'h40000 + 20'(i * 16), 3'(i), p, 1, 0);
      end
      p = pats[2];
      rd(benc(p) ^ (72'd1 << 3) ^ (72'd1 << 40), 20'h7FFF8, 3'd7, p ^ (64'd1 << 3) ^ (64'd1 << 40), 0, 1);
      check(flag_det == 0 && nmi_req == 0, "R8 locked det flag", {flag_det, nmi_req}, 0);
      check(capt_addr == align(20'hABCDF) && capt_master == 3'd5, "R8 capture held",
            {capt_addr, capt_master}, {align(20'hABCDF), 3'd5});

      // R9 clear
      wr(3'b101);
      check(flag_corr == 0 && irq_corr == 0, "R9 clear corr", {flag_corr, irq_corr}, 0);

      // R7 double error, enable off
      wr(3'b000);
      p = pats[1];
      rd(benc(p) ^ (72'd1 << 0) ^ (72'd1 << 71), 20'h12345, 3'd2, p ^ 64'd1, 0, 1);
      check(flag_det == 1 && nmi_req == 1, "R7 det flag and nmi", {flag_det, nmi_req}, 2'b11);
      check(flag_corr == 0, "R7 corr flag clear", flag_corr, 0);
      check(capt_addr == align(20'h12345) && capt_master == 3'd2, "R5 capture on det",
            {capt_addr, capt_master}, {align(20'h12345), 3'd2});

      // R4 double pairs, R8 locked by det
      for (int i = 0; i < 72; i++) begin
         int j;
         j = (i * 5 + 7) % 72;
         if (j == i) j = (i + 1) % 72;
         p = pats[(i + 2) % 5] ^ {32'(i), 32'(j)};
         w = benc(p) ^ (72'd1 << i) ^ (72'd1 << j);
         rd(w, 20'h20000 + 20'(i * 8), 3'(i + 1), w[63:0], 0, 1);
      end
      rd(benc(pats[0]) ^ (72'd1 << 70), 20'h00008, 3'd1, pats[0], 1, 0);
      check(flag_corr == 0, "R8 corr blocked by det", flag_corr, 0);
      check(capt_addr == align(20'h12345) && capt_master == 3'd2, "R8 capture held by det",
            {capt_addr, capt_master}, {align(20'h12345), 3'd2});

      wr(3'b010);
      check(nmi_req == 0 && flag_det == 0, "R9 clear det", {nmi_req, flag_det}, 0);

      // R9 clear and new error in the same cycle
      rd(benc(pats[4]) ^ (72'd1 << 33), 20'h00F0F, 3'd1, pats[4], 1, 0);
      check(flag_corr == 1, "R9 recapture after clear", flag_corr, 1);
      begin
         exp_t e;
         p = pats[2];
         w = benc(p) ^ (72'd1 << 5) ^ (72'd1 << 66);
         e.d = w[63:0]; e.c = 0; e.u = 1;
         sbq.push_back(e);
         @(negedge clk);
         cfg_wr = 1'b1; cfg_wdata = 3'b001;
         rd_valid = 1'b1; rd_word = w; rd_addr = 20'h3C3C7; rd_master = 3'd6;
         @(negedge clk);
         cfg_wr = 1'b0; rd_valid = 1'b0;
      end
      check(flag_corr == 0 && flag_det == 1, "R9 same-cycle clear and capture",
            {flag_corr, flag_det}, 2'b01);
      check(capt_addr == align(20'h3C3C7) && capt_master == 3'd6, "R9 same-cycle capture",
            {capt_addr, capt_master}, {align(20'h3C3C7), 3'd6});

      repeat (4) @(negedge clk);
      check(sbq.size() == 0, "R2 all outputs seen", sbq.size(), 0);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule